// File: doc/BRIEF.md
# External Memory Bus Controller

This block turns single memory requests from the processor core into cycles on a shared, multiplexed address/data bus. The core presents an address, write data, a size flag (byte or 16-bit word), a read/write flag and an instruction-fetch flag. It holds the request until the block returns a one-clock `done` pulse, with read data when the request was a read. Every external cycle runs through fixed phases. One clock drives the address with the address strobe. Two clocks follow in which the bus carries write data, or is released for read data, while the read or write strobe is active. The cycle ends with one idle clock.

A small configuration register selects three strobe styles at run time:

- the address strobe is either a latch pulse or an active-low address-valid level;
- the write pin is either one common write strobe or a low-lane write strobe;
- the high-byte pin is either a byte-lane select or a high-lane write strobe.

A further configuration bit lets a pin choose the bus width for each cycle. A word access on an 8-bit cycle is split into two byte cycles.

A memory-select input routes a fixed address window to on-chip memory. Requests in that window complete after one clock, take their data from the internal read port and leave every bus pin at rest.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, `done`=0, `rd_n`=1, `wr_lo_n`=1, `hi_sel_n`=1, `fetch_ind`=0 and `ad_oe`=0. The configuration register resets to 0, so `as_strobe`=0 (latch style).
- R2: `cfg_we`=1 loads `cfg_wdata` into the configuration register at the clock edge. The bits are:
  - bit0: 1 selects the address-valid style;
  - bit1: 1 selects per-cycle width;
  - bit2: 1 selects the split (low-lane) write pin;
  - bit3: 1 selects the write-high style of the high pin.

  A request takes the configuration value present at its acceptance edge. A write landing on that same edge applies only to later requests.
- R3: With bit1 set, `width_pin` is sampled at acceptance: 1 gives a 16-bit cycle and 0 gives an 8-bit cycle. With bit1 clear, every cycle is 8 bits wide whatever `width_pin` is.
- R4: An external cycle has one address clock, two strobe clocks and one idle clock. `done` is high in the idle clock, which is the fourth clock after the acceptance edge. Read data is captured at the end of the last strobe clock.
- R5: A word access on an 8-bit cycle runs two back-to-back byte cycles. The first is at the even address and carries the low byte. The second is at address+1 and carries the high byte. A single `done` appears in the eighth clock after acceptance.
- R6: In latch style, `as_strobe` is high for exactly the one address clock of each external cycle and low otherwise.
- R7: In address-valid style, `as_strobe` is low from the address clock through the last strobe clock (three clocks per byte cycle) and high at all other times.
- R8: `rd_n` is low only for the two strobe clocks of an external read, and `ad_oe`=0 while it is low.
- R9: With bit2 clear, `wr_lo_n` is low for the two strobe clocks of every external write. With bit2 set, it is low only when the low byte lane is written. On a 16-bit cycle that means a word or an even address. On an 8-bit cycle every byte travels the low lane.
- R10: With bit3 clear, `hi_sel_n` is low in the address and strobe clocks of 16-bit cycles that use the high lane (a word or an odd address), and high in 8-bit cycles. With bit3 set, it is low only in the strobe clocks of 16-bit writes that use the high lane.
- R11: `fetch_ind` is high in the address and strobe clocks of an external read with `req_fetch`=1, and low for data reads, writes and internal requests.
- R12: When `mem_sel`=1 and the address lies in 0x2000..0x5FFF inclusive, the request completes with `done` in the first clock after acceptance. `rdata` then equals `int_rd_data` sampled at acceptance, and no bus strobe moves. Any other address, or `mem_sel`=0, produces an external cycle.
- R13: Lanes on a 16-bit cycle:
  - a word uses `ad[15:0]`;
  - a byte uses `ad[7:0]` at an even address and `ad[15:8]` at an odd one;
  - a byte write drives its byte on both lanes;
  - a byte read returns the byte in `rdata[7:0]` with zero above.

  An 8-bit cycle uses `ad[7:0]` only. The address is driven in the address clock, and write data in the strobe clocks.
- R14: `done` is a single-clock pulse. No new request is accepted until the running one has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 4 | Configuration value |
| mem_sel | input | 1 | 1 routes the internal window on-chip |
| width_pin | input | 1 | Per-cycle width select (1 = 16-bit) |
| req_valid | input | 1 | Request held until done |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Write data |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch |
| int_rd_data | input | 16 | Read data from on-chip memory |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data |
| ad_in | input | 16 | Bus value seen on the pins |
| ad_out | output | 16 | Bus value driven: address, then write data |
| ad_oe | output | 1 | Bus output enable |
| as_strobe | output | 1 | Address latch pulse or active-low address valid |
| rd_n | output | 1 | Read strobe, active low |
| wr_lo_n | output | 1 | Write or low-lane write strobe, active low |
| hi_sel_n | output | 1 | High-lane select or high-lane write, active low |
| fetch_ind | output | 1 | Instruction-fetch indicator |

## Verification
Two things can land on one clock edge: a configuration write and the acceptance of a request. The bench provokes this by raising `cfg_we` and `req_valid` in the same clock. The new value turns per-cycle width off while `width_pin` requests 16 bits. The verdict comes from the completion latency of that request and of the next one. The first must still take the four clocks of a 16-bit cycle, and the second the eight clocks of a split 8-bit cycle.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int CFG_W     = 4;
  localparam int CFG_ADV   = 0;
  localparam int CFG_DYN   = 1;
  localparam int CFG_SPLIT = 2;
  localparam int CFG_WRH   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_GAP,
    ST_INT
  } ebc_state_e;

  typedef struct packed {
    logic wrh_mode;
    logic split_wr;
    logic adv_mode;
  } ebc_style_t;
endpackage

// File: rtl/ebc_window.sv
module ebc_window #(
  parameter int AW = 16,
  parameter logic [AW-1:0] WIN_LO = 16'h2000,
  parameter logic [AW-1:0] WIN_HI = 16'h5FFF
) (
  input  logic [AW-1:0] addr,
  input  logic          mem_sel,
  output logic          is_internal
);
  always_comb begin
    is_internal = mem_sel && (addr >= WIN_LO) && (addr <= WIN_HI);
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int AW = 16,
  parameter int BYTE_W = 8,
  localparam int DW = 2 * BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_word,
  input  logic          req_write,
  input  logic          req_fetch,
  input  logic          is_internal,
  input  logic          wide_sel,
  input  ebc_style_t    style_in,
  input  logic [DW-1:0] ad_in,
  input  logic [DW-1:0] int_rd_data,
  output ebc_state_e    state,
  output ebc_style_t    style_q,
  output logic          cyc_write,
  output logic          cyc_fetch,
  output logic          lane_lo,
  output logic          lane_hi,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] wbus,
  output logic [DW-1:0] rdata,
  output logic          done
);
  ebc_state_e    state_q, state_d;
  logic          beat_q, beat_d;
  logic          second_q, second_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, cap;
  logic          write_q, fetch_q, word_q, wide_q, split_q;
  ebc_style_t    style_r;
  logic          accept, last_beat, more, a0;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign last_beat = (state_q == ST_DATA) && beat_q;
  assign more      = split_q && !second_q;
  assign a0        = addr_q[0] | second_q;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    beat_d   = beat_q;
    second_d = second_q;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        state_d  = is_internal ? ST_INT : ST_ADDR;
        second_d = 1'b0;
      end
      ST_ADDR: begin
        state_d = ST_DATA;
        beat_d  = 1'b0;
      end
      ST_DATA: if (beat_q) state_d = ST_GAP;
               else        beat_d  = 1'b1;
      ST_GAP: if (more) begin
        state_d  = ST_ADDR;
        second_d = 1'b1;
      end else begin
        state_d = ST_IDLE;
      end
      ST_INT:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      beat_q   <= 1'b0;
      second_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      beat_q   <= beat_d;
      second_q <= second_d;
    end
  end

  // read lane capture
  always_comb begin
    if (wide_q) begin
      if (word_q) cap = ad_in;
      else        cap = {{BYTE_W{1'b0}}, a0 ? ad_in[DW-1:BYTE_W] : ad_in[BYTE_W-1:0]};
    end else if (second_q) begin
      cap = {ad_in[BYTE_W-1:0], rdata_q[BYTE_W-1:0]};
    end else begin
      cap = {{BYTE_W{1'b0}}, ad_in[BYTE_W-1:0]};
    end
  end

  // cycle context, loaded with clock enables
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
      fetch_q <= req_fetch;
      word_q  <= req_word;
      wide_q  <= wide_sel;
      split_q <= req_word && !wide_sel;
      style_r <= style_in;
    end
    if (accept && is_internal)          rdata_q <= int_rd_data;
    else if (last_beat && !write_q)     rdata_q <= cap;
  end

  always_comb begin
    if (wide_q) wbus = word_q ? wdata_q : {wdata_q[BYTE_W-1:0], wdata_q[BYTE_W-1:0]};
    else        wbus = {{BYTE_W{1'b0}}, second_q ? wdata_q[DW-1:BYTE_W] : wdata_q[BYTE_W-1:0]};
  end

  assign lane_lo   = wide_q ? (word_q || !a0) : 1'b1;
  assign lane_hi   = wide_q && (word_q || a0);
  assign cur_addr  = {addr_q[AW-1:1], a0};
  assign state     = state_q;
  assign style_q   = style_r;
  assign cyc_write = write_q;
  assign cyc_fetch = fetch_q;
  assign rdata     = rdata_q;
  assign done      = ((state_q == ST_GAP) && !more) || (state_q == ST_INT);
endmodule

// File: rtl/ebc_pins.sv
module ebc_pins
  import ebc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  ebc_state_e    state,
  input  logic          adv_mode,
  input  logic          split_wr,
  input  logic          wrh_mode,
  input  logic          cyc_write,
  input  logic          cyc_fetch,
  input  logic          lane_lo,
  input  logic          lane_hi,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] wbus,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          as_strobe,
  output logic          rd_n,
  output logic          wr_lo_n,
  output logic          hi_sel_n,
  output logic          fetch_ind
);
  logic in_addr, in_data, on_bus;

  always_comb begin
    in_addr   = (state == ST_ADDR);
    in_data   = (state == ST_DATA);
    on_bus    = in_addr || in_data;
    as_strobe = adv_mode ? !on_bus : in_addr;
    rd_n      = !(in_data && !cyc_write);
    wr_lo_n   = !(in_data && cyc_write && (split_wr ? lane_lo : 1'b1));
    hi_sel_n  = wrh_mode ? !(in_data && cyc_write && lane_hi) : !(on_bus && lane_hi);
    fetch_ind = on_bus && !cyc_write && cyc_fetch;
    ad_oe     = in_addr || (in_data && cyc_write);
    ad_out    = in_addr ? DW'(cur_addr) : wbus;
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int AW = 16,
  parameter int BYTE_W = 8,
  parameter logic [AW-1:0] WIN_LO = 16'h2000,
  parameter logic [AW-1:0] WIN_HI = 16'h5FFF,
  localparam int DW = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             mem_sel,
  input  logic             width_pin,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             req_word,
  input  logic             req_write,
  input  logic             req_fetch,
  input  logic [DW-1:0]    int_rd_data,
  output logic             done,
  output logic [DW-1:0]    rdata,
  input  logic [DW-1:0]    ad_in,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic             as_strobe,
  output logic             rd_n,
  output logic             wr_lo_n,
  output logic             hi_sel_n,
  output logic             fetch_ind
);
  logic [CFG_W-1:0] cfg_q;
  ebc_state_e       state;
  ebc_style_t       style_in, style_q;
  logic             is_internal, wide_sel, adv_eff;
  logic             cyc_write, cyc_fetch, lane_lo, lane_hi;
  logic [AW-1:0]    cur_addr;
  logic [DW-1:0]    wbus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_comb begin
    style_in.wrh_mode = cfg_q[CFG_WRH];
    style_in.split_wr = cfg_q[CFG_SPLIT];
    style_in.adv_mode = cfg_q[CFG_ADV];
    wide_sel          = cfg_q[CFG_DYN] && width_pin;
    adv_eff           = (state == ST_IDLE) ? cfg_q[CFG_ADV] : style_q.adv_mode;
  end

  ebc_window #(.AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
    .addr(req_addr), .mem_sel(mem_sel), .is_internal(is_internal)
  );

  ebc_seq #(.AW(AW), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_word(req_word), .req_write(req_write),
    .req_fetch(req_fetch), .is_internal(is_internal), .wide_sel(wide_sel),
    .style_in(style_in), .ad_in(ad_in), .int_rd_data(int_rd_data),
    .state(state), .style_q(style_q), .cyc_write(cyc_write), .cyc_fetch(cyc_fetch),
    .lane_lo(lane_lo), .lane_hi(lane_hi), .cur_addr(cur_addr), .wbus(wbus),
    .rdata(rdata), .done(done)
  );

  ebc_pins #(.AW(AW), .DW(DW)) u_pins (
    .state(state), .adv_mode(adv_eff), .split_wr(style_q.split_wr),
    .wrh_mode(style_q.wrh_mode), .cyc_write(cyc_write), .cyc_fetch(cyc_fetch),
    .lane_lo(lane_lo), .lane_hi(lane_hi), .cur_addr(cur_addr), .wbus(wbus),
    .ad_out(ad_out), .ad_oe(ad_oe), .as_strobe(as_strobe), .rd_n(rd_n),
    .wr_lo_n(wr_lo_n), .hi_sel_n(hi_sel_n), .fetch_ind(fetch_ind)
  );
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic rd_n,
  input logic wr_lo_n,
  input logic hi_sel_n,
  input logic ad_oe,
  input logic fetch_ind
);
  // R14
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R8
  rd_two_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> !rd_n);

  // R4
  rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |=> rd_n);

  // R9
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_lo_n));

  // R10
  hi_sel_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_sel_n |-> (ad_oe || !rd_n));

  // R11
  fetch_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ind |-> (wr_lo_n && (ad_oe || !rd_n)));
endmodule

bind ext_bus_ctrl ebc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .rd_n(rd_n), .wr_lo_n(wr_lo_n),
  .hi_sel_n(hi_sel_n), .ad_oe(ad_oe), .fetch_ind(fetch_ind)
);

// File: tb/ext_bus_ctrl_test.sv
module ext_bus_ctrl_test;
  localparam int CLK_P = 10;

  logic clk, rst_n, cfg_we, mem_sel, width_pin;
  logic [3:0] cfg_wdata;
  logic req_valid, req_word, req_write, req_fetch;
  logic [15:0] req_addr, req_wdata, int_rd_data, rdata, ad_in, ad_out;
  logic done, ad_oe, as_strobe, rd_n, wr_lo_n, hi_sel_n, fetch_ind;

  int errors, checks, lat;
  int n_as_hi, n_as_lo, n_rd, n_wrl, n_hi, n_fetch, n_done;
  logic cnt_en, m_adv, m_wrh, b16, prev_as, finished;
  logic [15:0] lat_addr, wcap, got;

  ext_bus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mem_sel(mem_sel), .width_pin(width_pin), .req_valid(req_valid),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_word(req_word),
    .req_write(req_write), .req_fetch(req_fetch), .int_rd_data(int_rd_data),
    .done(done), .rdata(rdata), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .as_strobe(as_strobe), .rd_n(rd_n), .wr_lo_n(wr_lo_n), .hi_sel_n(hi_sel_n),
    .fetch_ind(fetch_ind)
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign ad_in = {mem(lat_addr | 16'h0001), b16 ? mem(lat_addr & 16'hFFFE) : mem(lat_addr)};

  initial begin
    clk = 1'b0;
    forever #(CLK_P / 2) clk = ~clk;
  end

  // bus observer: strobe counts and external memory model
  always @(negedge clk) begin
    if (cnt_en) begin
      if (as_strobe) n_as_hi++; else n_as_lo++;
      if (!rd_n) n_rd++;
      if (!wr_lo_n) n_wrl++;
      if (!hi_sel_n) n_hi++;
      if (fetch_ind) n_fetch++;
      if (done) n_done++;
      if (!wr_lo_n || (m_wrh && !hi_sel_n)) wcap = ad_out;
    end
    if (m_adv ? (!as_strobe && prev_as) : as_strobe) lat_addr = ad_out;
    prev_as = as_strobe;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [3:0] v, input logic adv, input logic wrh);
    cfg_wdata = v; cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0; m_adv = adv; m_wrh = wrh;
  endtask

  task automatic run_req(input logic [15:0] a, input logic w, input logic wr,
                         input logic f, input logic [15:0] wd);
    n_as_hi = 0; n_as_lo = 0; n_rd = 0; n_wrl = 0; n_hi = 0; n_fetch = 0; n_done = 0;
    cnt_en = 1'b1;
    req_addr = a; req_word = w; req_write = wr; req_fetch = f; req_wdata = wd;
    req_valid = 1'b1; lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
    end while (!done && lat < 40);
    got = rdata;
    req_valid = 1'b0; cfg_we = 1'b0;
    @(posedge clk); #1;
    cnt_en = 1'b0;
    if (lat >= 40) chk("R14 request never completed", 0, 1);
  endtask

  task automatic t_reset;
    chk("R1 done", done, 0);
    chk("R1 rd_n", rd_n, 1);
    chk("R1 wr_lo_n", wr_lo_n, 1);
    chk("R1 hi_sel_n", hi_sel_n, 1);
    chk("R1 fetch_ind", fetch_ind, 0);
    chk("R1 ad_oe", ad_oe, 0);
    chk("R1 as_strobe", as_strobe, 0);
  endtask

  task automatic t_word16;
    set_cfg(4'b0010, 1'b0, 1'b0); width_pin = 1'b1; b16 = 1'b1; mem_sel = 1'b0;
    run_req(16'h1234, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R4 latency 16-bit", lat, 4);
    chk("R13 word read data", got, {mem(16'h1235), mem(16'h1234)});
    chk("R8 read strobe clocks", n_rd, 2);
    chk("R6 latch pulse clocks", n_as_hi, 1);
    chk("R14 done pulses", n_done, 1);
    chk("R10 hi_sel word read", n_hi, 3);
    chk("R11 data read no fetch", n_fetch, 0);
  endtask

  task automatic t_split;
    set_cfg(4'b0000, 1'b0, 1'b0); width_pin = 1'b1; b16 = 1'b0;
    run_req(16'h0A40, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R3 width pin ignored latency", lat, 8);
    chk("R5 split read data", got, {mem(16'h0A41), mem(16'h0A40)});
    chk("R5 read strobe clocks", n_rd, 4);
    chk("R6 two latch pulses", n_as_hi, 2);
    chk("R10 8-bit no hi_sel", n_hi, 0);
    chk("R5 single done", n_done, 1);
    set_cfg(4'b0010, 1'b0, 1'b0); width_pin = 1'b0;
    run_req(16'h0B00, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R3 width pin low gives 8-bit", lat, 8);
  endtask

  task automatic t_fetch;
    set_cfg(4'b0010, 1'b0, 1'b0); width_pin = 1'b1; b16 = 1'b1;
    run_req(16'h0101, 1'b0, 1'b0, 1'b1, 16'h0);
    chk("R11 fetch clocks", n_fetch, 3);
    chk("R13 odd byte read", got, {8'h00, mem(16'h0101)});
    chk("R10 odd byte hi_sel", n_hi, 3);
    run_req(16'h0100, 1'b0, 1'b0, 1'b1, 16'h0);
    chk("R13 even byte read", got, {8'h00, mem(16'h0100)});
    chk("R10 even byte no hi_sel", n_hi, 0);
  endtask

  task automatic t_internal;
    mem_sel = 1'b1; int_rd_data = 16'hBEEF;
    run_req(16'h3000, 1'b1, 1'b0, 1'b1, 16'h0);
    chk("R12 internal latency", lat, 1);
    chk("R12 internal data", got, 16'hBEEF);
    chk("R12 no read strobe", n_rd, 0);
    chk("R12 no address strobe", n_as_hi, 0);
    chk("R11 no fetch internal", n_fetch, 0);
    run_req(16'h5FFF, 1'b0, 1'b1, 1'b0, 16'h0011);
    chk("R12 top of window", lat, 1);
    chk("R12 no write strobe", n_wrl, 0);
    run_req(16'h2000, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R12 bottom of window", lat, 1);
    run_req(16'h6000, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R12 above window external", lat, 4);
    run_req(16'h1FFF, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R12 below window external", lat, 4);
    mem_sel = 1'b0;
    run_req(16'h3000, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R12 mem_sel low external", lat, 4);
    chk("R12 mem_sel low read strobe", n_rd, 2);
  endtask

  task automatic t_write;
    set_cfg(4'b0010, 1'b0, 1'b0); width_pin = 1'b1; b16 = 1'b1;
    run_req(16'h0200, 1'b1, 1'b1, 1'b0, 16'hA55A);
    chk("R9 single write clocks", n_wrl, 2);
    chk("R13 word write lanes", wcap, 16'hA55A);
    chk("R8 no read strobe on write", n_rd, 0);
    chk("R10 hi_sel word write", n_hi, 3);
    run_req(16'h0201, 1'b0, 1'b1, 1'b0, 16'h0077);
    chk("R9 single mode odd byte", n_wrl, 2);
    set_cfg(4'b1110, 1'b0, 1'b1);
    run_req(16'h0301, 1'b0, 1'b1, 1'b0, 16'h0033);
    chk("R9 split odd byte no low strobe", n_wrl, 0);
    chk("R10 write-high odd byte", n_hi, 2);
    chk("R13 odd byte on high lane", wcap[15:8], 8'h33);
    run_req(16'h0300, 1'b0, 1'b1, 1'b0, 16'h0044);
    chk("R9 split even byte", n_wrl, 2);
    chk("R10 write-high even byte", n_hi, 0);
    chk("R13 even byte on low lane", wcap[7:0], 8'h44);
    run_req(16'h0302, 1'b1, 1'b1, 1'b0, 16'h1234);
    chk("R9 split word low strobe", n_wrl, 2);
    chk("R10 write-high word", n_hi, 2);
    set_cfg(4'b1100, 1'b0, 1'b1); b16 = 1'b0;
    run_req(16'h0400, 1'b1, 1'b1, 1'b0, 16'hC3D4);
    chk("R9 8-bit split every byte", n_wrl, 4);
    chk("R5 split write latency", lat, 8);
    chk("R10 8-bit no write-high", n_hi, 0);
    chk("R5 high byte second", wcap[7:0], 8'hC3);
  endtask

  task automatic t_adv;
    set_cfg(4'b0011, 1'b1, 1'b0); width_pin = 1'b1; b16 = 1'b1;
    chk("R7 idle high in valid style", as_strobe, 1);
    run_req(16'h0810, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R7 valid low clocks", n_as_lo, 3);
    chk("R7 read data via valid latch", got, {mem(16'h0811), mem(16'h0810)});
    chk("R7 high after cycle", as_strobe, 1);
    set_cfg(4'b0001, 1'b1, 1'b0); b16 = 1'b0;
    run_req(16'h0820, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R7 valid low split", n_as_lo, 6);
    chk("R5 split data valid style", got, {mem(16'h0821), mem(16'h0820)});
  endtask

  task automatic t_overlap;
    set_cfg(4'b0010, 1'b0, 1'b0); width_pin = 1'b1; b16 = 1'b1;
    cfg_wdata = 4'b0000; cfg_we = 1'b1;
    run_req(16'h0C00, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R2 same-edge write keeps old config", lat, 4);
    b16 = 1'b0;
    run_req(16'h0C02, 1'b1, 1'b0, 1'b0, 16'h0);
    chk("R2 new config on next request", lat, 8);
  endtask

  initial begin
    errors = 0; checks = 0; finished = 1'b0; cnt_en = 1'b0;
    m_adv = 1'b0; m_wrh = 1'b0; b16 = 1'b1; prev_as = 1'b0; lat_addr = '0; wcap = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; mem_sel = 1'b0; width_pin = 1'b0;
    req_valid = 1'b0; req_word = 1'b0; req_write = 1'b0; req_fetch = 1'b0;
    req_addr = '0; req_wdata = '0; int_rd_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 done in reset", done, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset;
    t_word16;
    t_split;
    t_fetch;
    t_internal;
    t_write;
    t_adv;
    t_overlap;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule